// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block steps through the double-word beats of one transfer on a 64-bit data bus. The bus is built from a high 32-bit half and a low 32-bit half. A start request captures a byte address and the shape of the transfer. The shape is one of three: a four-beat line burst, a single beat, or a 128-bit uncached vector access. For each beat the block gives the double-word address, the beat index, a last-beat flag and a burst/single indicator. It moves to the next beat only when the data acknowledge arrives.

A burst always covers one aligned 32-byte line in four double-word beats. When critical-first ordering is requested for a cacheable miss, the burst starts at the double word that holds the requested data and wraps around inside the line. Without that request, it starts at the first double word of the line. A single beat moves up to eight bytes at the double word that contains the address. A 128-bit uncached or write-through vector access becomes two separate single-beat transactions, covering the aligned 16-byte pair. The request for a burst is raised by the caller only for caching-allowed accesses, and for stores only when the page is in write-back mode.

Top module: `burst_beat_seq`

## Requirements
- R1: While reset is held and right after it, `active`, `done`, `lastBeat` and `burstInd` are 0.
- R2: A `startReq` sampled while idle begins a transfer. From the next cycle `active` is 1 and `beatIdx` is 0.
- R3: With `burstReq`=1 and `critFirst`=1, beat i has address bits [31:5] equal to those of `startAddr`, bits [4:3] equal to (`startAddr`[4:3] + i) mod 4, and bits [2:0] equal to 0. The burst therefore wraps inside the 32-byte line.
- R4: With `burstReq`=1 and `critFirst`=0, beat i has address (`startAddr` with bits [4:0] cleared) + 8*i.
- R5: `burstInd` is 1 on every beat of a burst and 0 on single beats. `beatIdx` counts 0,1,2,3 over a burst and is 0 on single beats.
- R6: The beat address and `beatIdx` change only after a cycle in which `dataAck` is 1. While `dataAck` is 0 they hold.
- R7: `lastBeat` is 1 only while `active`. It is 1 on the fourth beat of a burst and on every single beat, and 0 on the first three burst beats.
- R8: `done` is 1 for exactly one cycle: the cycle after the acknowledge of the final beat. In that same cycle `active` is 0.
- R9: With `burstReq`=0 and `vec128`=0, the transfer is one beat at `startAddr` with bits [2:0] cleared.
- R10: With `burstReq`=0 and `vec128`=1, the transfer is two single beats, at `startAddr` with bits [3:0] cleared and then that address + 8. `done` follows only the second acknowledge.
- R11: When `burstReq`=1, `vec128` has no effect and a normal burst runs.
- R12: A `startReq` that arrives while a transfer is active is ignored. The running beat sequence continues unchanged.
- R13: A `dataAck` while idle is ignored. `done` stays 0 and no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a transfer (taken only while idle) |
| startAddr | input | 32 | Byte address of the requested data |
| burstReq | input | 1 | 1 = four-beat line burst, 0 = single-beat transfer |
| critFirst | input | 1 | Start a burst at the critical double word |
| vec128 | input | 1 | Single-beat 128-bit vector access, split into two beats |
| dataAck | input | 1 | Acknowledge of the current beat |
| active | output | 1 | A transfer is in progress |
| burstInd | output | 1 | Current transaction is a four-beat burst |
| beatAddr | output | 32 | Double-word-aligned address of the current beat |
| beatIdx | output | 2 | Index of the current beat within the burst |
| lastBeat | output | 1 | Current beat is the final beat of its transaction |
| done | output | 1 | One-cycle pulse after the final acknowledge |

## Verification
A wrong beat offset or a wrong start offset shows at once on `beatAddr` bits [4:3], on the first beat or the beat after an acknowledge. A beat counter that slips shows as an early or late `lastBeat` and `done`, one acknowledge away from the expected beat. A control state that fails to guard the idle and active phases shows within a cycle, either as a restarted address after a stray start request or as a `done` pulse after a stray acknowledge. The sweep covers all 32 byte offsets in a line for every transfer shape, with and without wait cycles between acknowledges.

// File: rtl/bbas_pkg.sv
package bbas_pkg;
  localparam int DW_BYTES = 8;
  localparam int DW_LSB   = $clog2(DW_BYTES);

  typedef enum logic {ST_IDLE, ST_RUN} bbasState_t;

  typedef struct packed {
    logic load;    // capture a new transfer
    logic step;    // acknowledged beat, more to come
    logic finish;  // acknowledged final beat
  } bbasStrobe_t;
endpackage

// File: rtl/bbas_ctrl.sv
module bbas_ctrl
  import bbas_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        dataAck,
  input  logic        isFinal,
  output bbasStrobe_t strobe,
  output logic        active,
  output logic        done
);
  bbasState_t stateQ;

  assign active = (stateQ == ST_RUN);

  always_comb begin
    strobe        = '0;
    strobe.load   = !active && startReq;
    strobe.step   = active && dataAck && !isFinal;
    strobe.finish = active && dataAck && isFinal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.load)        stateQ <= ST_RUN;
      else if (strobe.finish) stateQ <= ST_IDLE;
    end
  end

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !active);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R12
  stay_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !(dataAck && isFinal)) |=> active);
  // R13
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !startReq) |=> (!active && !$rose(done)));
endmodule

// File: rtl/bbas_dpath.sv
module bbas_dpath
  import bbas_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BEATS  = 4
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  bbasStrobe_t                strobe,
  input  logic                       active,
  input  logic [ADDR_W-1:0]          startAddr,
  input  logic                       burstReq,
  input  logic                       critFirst,
  input  logic                       vec128,
  output logic [ADDR_W-1:0]          beatAddr,
  output logic [$clog2(BEATS)-1:0]   beatIdx,
  output logic                       burstInd,
  output logic                       lastBeat,
  output logic                       isFinal
);
  localparam int OFF_W    = $clog2(BEATS);
  localparam int LINE_LSB = DW_LSB + OFF_W;
  localparam logic [OFF_W-1:0] LAST_CNT = OFF_W'(BEATS - 1);
  localparam logic [OFF_W-1:0] PAIR_MASK = ~OFF_W'(1);

  logic [ADDR_W-1:LINE_LSB] lineTag;
  logic [OFF_W-1:0]         startOff, beatCnt, curOff, reqOff;
  logic                     partQ, isBurstQ, isVecQ;

  assign reqOff = startAddr[DW_LSB +: OFF_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineTag  <= '0;
      startOff <= '0;
      beatCnt  <= '0;
      partQ    <= 1'b0;
      isBurstQ <= 1'b0;
      isVecQ   <= 1'b0;
    end else if (strobe.load) begin
      lineTag  <= startAddr[ADDR_W-1:LINE_LSB];
      beatCnt  <= '0;
      partQ    <= 1'b0;
      isBurstQ <= burstReq;
      isVecQ   <= !burstReq && vec128;
      if (burstReq)   startOff <= critFirst ? reqOff : '0;
      else if (vec128) startOff <= reqOff & PAIR_MASK;
      else            startOff <= reqOff;
    end else if (strobe.step) begin
      if (isBurstQ) beatCnt <= beatCnt + 1'b1;
      else          partQ   <= 1'b1;
    end
  end

  assign curOff   = startOff + beatCnt + OFF_W'(partQ);
  assign beatAddr = {lineTag, curOff, {DW_LSB{1'b0}}};
  assign beatIdx  = beatCnt;
  assign burstInd = active && isBurstQ;
  assign lastBeat = active && (!isBurstQ || beatCnt == LAST_CNT);
  assign isFinal  = isBurstQ ? (beatCnt == LAST_CNT) : (!isVecQ || partQ);

  // R6
  hold_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !strobe.step && !strobe.finish) |=> ($stable(beatAddr) && $stable(beatIdx)));
  // R3
  wrap_in_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && burstInd) |=>
      (beatAddr[ADDR_W-1:LINE_LSB] == $past(beatAddr[ADDR_W-1:LINE_LSB]) &&
       beatAddr[LINE_LSB-1:DW_LSB] == OFF_W'($past(beatAddr[LINE_LSB-1:DW_LSB]) + 1'b1)));
  // R7
  last_when_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> active);
  // R5
  single_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !burstInd) |-> (beatIdx == '0));
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq
  import bbas_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BEATS  = 4
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startReq,
  input  logic [ADDR_W-1:0]        startAddr,
  input  logic                     burstReq,
  input  logic                     critFirst,
  input  logic                     vec128,
  input  logic                     dataAck,
  output logic                     active,
  output logic                     burstInd,
  output logic [ADDR_W-1:0]        beatAddr,
  output logic [$clog2(BEATS)-1:0] beatIdx,
  output logic                     lastBeat,
  output logic                     done
);
  bbasStrobe_t strobe;
  logic        isFinal;

  bbas_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dataAck(dataAck),
    .isFinal(isFinal), .strobe(strobe), .active(active), .done(done)
  );

  bbas_dpath #(.ADDR_W(ADDR_W), .BEATS(BEATS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .active(active),
    .startAddr(startAddr), .burstReq(burstReq), .critFirst(critFirst),
    .vec128(vec128), .beatAddr(beatAddr), .beatIdx(beatIdx),
    .burstInd(burstInd), .lastBeat(lastBeat), .isFinal(isFinal)
  );
endmodule

// File: tb/burst_beat_seq_tb.sv
module burst_beat_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] startAddr = '0;
  logic        burstReq = 1'b0, critFirst = 1'b0, vec128 = 1'b0, dataAck = 1'b0;
  logic        active, burstInd, lastBeat, done;
  logic [31:0] beatAddr;
  logic [1:0]  beatIdx;
  int          nRun = 0, nFail = 0;

  always #10 clk = ~clk;

  burst_beat_seq u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .burstReq(burstReq), .critFirst(critFirst), .vec128(vec128),
    .dataAck(dataAck), .active(active), .burstInd(burstInd),
    .beatAddr(beatAddr), .beatIdx(beatIdx), .lastBeat(lastBeat), .done(done)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // kind: 0 burst crit, 1 burst line-aligned, 2 single, 3 vector pair, 4 burst with vec128 set
  task automatic runXfer(logic [31:0] addr, int kind, bit gap);
    bit isB = (kind == 0 || kind == 1 || kind == 4);
    int nBeats = isB ? 4 : (kind == 3 ? 2 : 1);
    logic [31:0] base;
    logic [1:0]  off;
    logic [31:0] exp;
    base = addr & ~32'h1f;
    off  = (kind == 1 || kind == 4) ? 2'd0 :
           (kind == 3) ? {addr[4], 1'b0} : addr[4:3];
    startAddr = addr;
    burstReq  = isB;
    critFirst = (kind == 0) || (kind == 2);
    vec128    = (kind >= 3);
    startReq  = 1'b1;
    cyc();
    startReq  = 1'b0;
    check("R2 active", {31'b0, active}, 32'd1);
    for (int i = 0; i < nBeats; i++) begin
      exp = base | ({30'b0, 2'(off + 2'(i))} << 3);
      check(kind == 0 ? "R3 addr" : kind == 2 ? "R9 addr" : kind == 3 ? "R10 addr" :
            kind == 4 ? "R11 addr" : "R4 addr", beatAddr, exp);
      check("R5 idx", {30'b0, beatIdx}, isB ? 32'(i) : 32'd0);
      check("R5 burstInd", {31'b0, burstInd}, {31'b0, isB});
      check("R7 lastBeat", {31'b0, lastBeat}, (!isB || i == 3) ? 32'd1 : 32'd0);
      check("R8 no early done", {31'b0, done}, 32'd0);
      if (gap) begin
        // R12: stray start with a different address while active
        startAddr = addr ^ 32'h0000_0018;
        burstReq  = !isB;
        startReq  = 1'b1;
        cyc();
        startReq  = 1'b0;
        check("R6 hold addr", beatAddr, exp);
        check("R12 no restart idx", {30'b0, beatIdx}, isB ? 32'(i) : 32'd0);
        check("R12 still active", {31'b0, active}, 32'd1);
      end
      dataAck = 1'b1;
      cyc();
      dataAck = 1'b0;
    end
    check("R8 done", {31'b0, done}, 32'd1);
    check("R8 inactive", {31'b0, active}, 32'd0);
    check("R7 no last idle", {31'b0, lastBeat}, 32'd0);
    cyc();
    check("R8 single pulse", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (3) cyc();
    // R1
    check("R1 active", {31'b0, active}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 lastBeat", {31'b0, lastBeat}, 32'd0);
    check("R1 burstInd", {31'b0, burstInd}, 32'd0);
    rstN = 1'b1;
    cyc();
    check("R1 after reset", {30'b0, active, done}, 32'd0);
    // R13: acknowledge while idle
    dataAck = 1'b1;
    cyc();
    cyc();
    dataAck = 1'b0;
    check("R13 done", {31'b0, done}, 32'd0);
    check("R13 active", {31'b0, active}, 32'd0);
    for (int k = 0; k < 5; k++)
      for (int a = 0; a < 32; a++)
        runXfer(32'h8A40_0000 | (32'(a) << 5) | 32'(a), k, a[0]);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule